// File: doc/BRIEF.md
# Dual Local Interrupt Controller

This block takes two interrupt lines from the local side, which run on no fixed relation to the bus clock, and folds them into a single active-low interrupt request toward the bus. Each line first crosses into the bus clock domain through a short synchronizer. It is then judged in one of two ways: as a level whose active sense is programmable, or as a rising edge that is held until software clears it.

Software sees one 12-bit control/status word. A write updates the per-channel enable, polarity and mode bits and the global enable. In the same write, two self-clearing bits can discard latched edges. A read returns the configuration and the live status of each channel. The request output goes low only when the global enable is on and at least one channel reports status.

Top module: `local_irq_merge`

## Requirements
- R1: After reset, every bit of the read word is 0 and `irqReqN` is 1.
- R2: Configuration bits read back where they were written. For channel c (0 or 1), enable is at bit 3c, polarity at bit 3c+1 and mode at bit 8+c. The global enable is at bit 6. Bits 7, 10 and 11 always read 0.
- R3: Status bits 2 (channel 0) and 5 (channel 1) are read-only, and a write to them does not change the value read back.
- R4: A channel is in level mode unless it is in edge mode (R5). In level mode its status is 1 exactly when it is enabled and its synchronized input equals its polarity bit, so polarity 0 means active-low and polarity 1 means active-high. The status drops when the input goes inactive or the channel is disabled.
- R5: A channel is in edge mode only when its mode, polarity and enable bits are all 1. If any of the three is 0, the channel behaves as in level mode.
- R6: In edge mode, a low-to-high transition of the synchronized input sets the status. The status stays set after the input falls.
- R7: Writing 1 to bit 10 clears the latched status of channel 0, and writing 1 to bit 11 clears that of channel 1. Neither bit affects the other channel.
- R8: If a rising edge is detected in the same clock in which its clear bit is written, the status stays set.
- R9: `irqReqN` is 0 exactly when the global enable is 1 and at least one status bit is 1.
- R10: An input change first shows in the status at the third rising clock edge after it. Two synchronizer flops come first, then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 2 | Raw local interrupt inputs, asynchronous |
| wrEn | input | 1 | Write strobe for the control/status word |
| wrData | input | 12 | Write data |
| rdData | output | 12 | Current control/status word |
| irqReqN | output | 1 | Active-low merged interrupt request |

## Verification
Two functions can fall in the same clock: a channel's edge detector can fire in the very cycle that software writes that channel's clear bit. The bench raises the input and counts the two synchronizer stages exactly. It then places the clear write so that it lands on the edge where the rising transition is captured, and expects the status still set afterwards. A separate clear write with no edge present must then drop it. Around that case, a sweep runs over every combination of enable, polarity and mode on both channels. It checks status and request against values derived from R4–R6 for high, low and cleared input phases.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int NumChan  = 2;
  localparam int GiePos   = 3 * NumChan;
  localparam int EdgeBase = GiePos + 2;
  localparam int ClrBase  = EdgeBase + NumChan;
  localparam int RegW     = ClrBase + NumChan;

  typedef struct packed {
    logic [NumChan-1:0] en;
    logic [NumChan-1:0] pol;
    logic [NumChan-1:0] edgeSel;
    logic               gie;
  } cfg_t;

  typedef struct packed {
    logic [NumChan-1:0] clr;
  } strobe_t;
endpackage

// File: rtl/lirq_ctl.sv
module lirq_ctl
  import lirq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [RegW-1:0] wrData,
  output cfg_t            cfg,
  output strobe_t         stb
);
  logic [NumChan-1:0] unusedStat;
  logic               unusedWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrEn) begin
      for (int c = 0; c < NumChan; c++) begin
        cfg.en[c]      <= wrData[3*c];
        cfg.pol[c]     <= wrData[3*c+1];
        cfg.edgeSel[c] <= wrData[EdgeBase+c];
      end
      cfg.gie <= wrData[GiePos];
    end
  end

  // write-one clear strobes last exactly one cycle
  always_comb begin
    stb.clr = wrEn ? wrData[ClrBase +: NumChan] : '0;
  end

  always_comb begin
    for (int c = 0; c < NumChan; c++) unusedStat[c] = wrData[3*c+2];
  end
  assign unusedWr = ^{unusedStat, wrData[GiePos+1]};
endmodule

// File: rtl/lirq_path.sv
module lirq_path
  import lirq_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumChan-1:0] irqIn,
  input  cfg_t               cfg,
  input  strobe_t            stb,
  output logic [NumChan-1:0] status
);
  logic [NumChan-1:0] edgeAct;
  logic [NumChan-1:0] rise;

  for (genvar c = 0; c < NumChan; c++) begin : g_chan
    logic [SyncStages-1:0] syncQ;
    logic                  prevQ;
    logic                  statusQ;
    logic                  syncd;

    assign syncd      = syncQ[SyncStages-1];
    assign edgeAct[c] = cfg.edgeSel[c] & cfg.pol[c] & cfg.en[c];
    assign rise[c]    = syncd & ~prevQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ   <= '0;
        prevQ   <= 1'b0;
        statusQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SyncStages-2:0], irqIn[c]};
        prevQ <= syncd;
        if (edgeAct[c]) statusQ <= rise[c] | (statusQ & ~stb.clr[c]);
        else            statusQ <= cfg.en[c] & (syncd == cfg.pol[c]);
      end
    end

    assign status[c] = statusQ;

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      (edgeAct[c] && statusQ && !stb.clr[c]) |=> statusQ);
    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
      (edgeAct[c] && rise[c]) |=> statusQ);
    assert_disabled_low_R4: assert property (@(posedge clk) disable iff (!rstN)
      !cfg.en[c] |=> !statusQ);
  end
endmodule

// File: rtl/local_irq_merge.sv
module local_irq_merge
  import lirq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      irqIn,
  input  logic            wrEn,
  input  logic [11:0]     wrData,
  output logic [11:0]     rdData,
  output logic            irqReqN
);
  cfg_t               cfg;
  strobe_t            stb;
  logic [NumChan-1:0] status;

  lirq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .cfg(cfg), .stb(stb)
  );

  lirq_path #(.SyncStages(2)) u_path (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .cfg(cfg), .stb(stb), .status(status)
  );

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NumChan; c++) begin
      rdData[3*c]          = cfg.en[c];
      rdData[3*c+1]        = cfg.pol[c];
      rdData[3*c+2]        = status[c];
      rdData[EdgeBase+c]   = cfg.edgeSel[c];
    end
    rdData[GiePos] = cfg.gie;
  end

  assign irqReqN = ~(cfg.gie & (|status));

  assert_req_active_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[GiePos] && (rdData[2] || rdData[5])) |-> !irqReqN);
  assert_req_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[GiePos] |-> irqReqN);
  assert_clr_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[11:10] == 2'b00);
endmodule

// File: tb/local_irq_merge_test.sv
module local_irq_merge_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  irqIn = 2'b00;
  logic        wrEn = 1'b0;
  logic [11:0] wrData = '0;
  logic [11:0] rdData;
  logic        irqReqN;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  local_irq_merge uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irqReqN(irqReqN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [11:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  function automatic logic [11:0] cfgWord(input int c, input bit en, input bit pol,
                                         input bit md, input bit gie);
    logic [11:0] w = '0;
    w[3*c] = en; w[3*c+1] = pol; w[8+c] = md; w[6] = gie;
    return w;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [11:0] w;
    waitCyc(3);
    check(rdData == 12'h000, "R1 reset read word", rdData, 0);
    check(irqReqN == 1'b1, "R1 reset request", irqReqN, 1);
    rstN = 1'b1;
    waitCyc(2);

    // R2: all-ones write, no input activity
    wrReg(12'hFFF);
    waitCyc(1);
    check(rdData == 12'h35B, "R2 readback layout", rdData, 12'h35B);
    check(irqReqN == 1'b1, "R9 no status no request", irqReqN, 1);

    // exhaustive sweep of en/pol/mode per channel (R4 R5 R6 R7 R9)
    for (int c = 0; c < 2; c++) begin
      for (int m = 0; m < 8; m++) begin
        bit en = m[0]; bit pol = m[1]; bit md = m[2];
        bit ea = en & pol & md;
        bit exp;
        w = cfgWord(c, en, pol, md, 1'b1);
        irqIn = 2'b00;
        wrReg(w | 12'hC00);
        waitCyc(5);
        wrReg(w | 12'hC00);
        waitCyc(3);
        exp = !ea && en && !pol;
        check(rdData[3*c+2] == exp, $sformatf("R4 low phase c%0d m%0d", c, m), rdData[3*c+2], exp);
        irqIn[c] = 1'b1;
        waitCyc(5);
        exp = en && pol;
        check(rdData[3*c+2] == exp, $sformatf("R5 high phase c%0d m%0d", c, m), rdData[3*c+2], exp);
        check(irqReqN == !exp, $sformatf("R9 request c%0d m%0d", c, m), irqReqN, !exp);
        irqIn[c] = 1'b0;
        waitCyc(5);
        exp = ea ? 1'b1 : (en && !pol);
        check(rdData[3*c+2] == exp, $sformatf("R6 after fall c%0d m%0d", c, m), rdData[3*c+2], exp);
        wrReg(w | (12'h400 << c));
        waitCyc(1);
        exp = ea ? 1'b0 : (en && !pol);
        check(rdData[3*c+2] == exp, $sformatf("R7 after clear c%0d m%0d", c, m), rdData[3*c+2], exp);
      end
    end

    // R10: latency of exactly three edges, level active-high on channel 0
    irqIn = 2'b00;
    wrReg(cfgWord(0, 1, 1, 0, 1));
    waitCyc(4);
    irqIn[0] = 1'b1;
    waitCyc(2);
    check(rdData[2] == 1'b0, "R10 not yet after two edges", rdData[2], 0);
    waitCyc(1);
    check(rdData[2] == 1'b1, "R10 visible at third edge", rdData[2], 1);

    // R3: status bits ignore writes (channel 0 active-low, input high)
    wrReg(cfgWord(0, 1, 0, 0, 1) | 12'h024);
    waitCyc(3);
    check(rdData[2] == 1'b0 && rdData[5] == 1'b0, "R3 status read-only", rdData, 12'h041);

    // R9: global enable off masks an active status
    wrReg(cfgWord(0, 1, 1, 0, 0));
    waitCyc(3);
    check(rdData[2] == 1'b1, "R9 status present", rdData[2], 1);
    check(irqReqN == 1'b1, "R9 masked by global enable", irqReqN, 1);

    // R7: clearing channel 0 leaves channel 1 latched
    irqIn = 2'b00;
    w = cfgWord(0, 1, 1, 1, 1) | cfgWord(1, 1, 1, 1, 1);
    wrReg(w | 12'hC00);
    waitCyc(4);
    irqIn = 2'b11;
    waitCyc(4);
    irqIn = 2'b00;
    waitCyc(4);
    wrReg(w | 12'h400);
    check(rdData[2] == 1'b0 && rdData[5] == 1'b1, "R7 per-channel clear", rdData, 12'h37B);

    // R8: rising edge captured in the same clock as the clear write
    wrReg(w | 12'hC00);
    waitCyc(3);
    irqIn[0] = 1'b1;
    waitCyc(2);
    wrEn = 1'b1; wrData = w | 12'h400;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    check(rdData[2] == 1'b1, "R8 edge beats clear", rdData[2], 1);
    wrReg(w | 12'h400);
    check(rdData[2] == 1'b0, "R7 later clear drops status", rdData[2], 0);
    check(rdData[11:10] == 2'b00, "R2 clear bits read zero", rdData[11:10], 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule